// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block is a fully associative address translation buffer that system software fills and inspects through a small set of control registers. Software stages an entry in the staging registers: the virtual page pair tag with its address-space identifier, two physical frame descriptors for the even and odd page, and a page size mask. It then commits that entry to a slot chosen either by the slot-number register or by a free-running replacement counter. Software can also copy a slot back into the staging registers, or search all slots for one that matches the staged tag.

A separate combinational lookup port takes a virtual page number at the smallest page granularity together with an address-space identifier. It returns the physical frame of the matching slot's even or odd half, along with that half's valid and dirty bits. Every command completes in one clock cycle, so there is no busy signal.

Each slot maps a pair of pages. A set bit in the slot's mask widens both pages by a factor of two, starting from the least significant mask bit. The replacement counter never goes below the floor register, so the slots below the floor are kept out of random replacement.

Top module: `tlb_top`

## Requirements
- R1: After reset, the slot-number register reads 0, the floor register reads 0, the replacement counter reads ENTRIES-1, and the staging tag, both descriptors and the mask read 0.
- R2: A command with funct code 2 stores the staged tag, mask and descriptors into the slot given by the low bits of the slot-number register. The lookup port observes the stored slot in the cycle after the command edge.
- R3: On a store, the slot's single global bit becomes the AND of bit 0 of both staged descriptors. A read-back writes that stored bit into bit 0 of both descriptors. A descriptor is {frame[PFN_W-1:0], dirty, valid, global}, with global in bit 0, valid in bit 1 and dirty in bit 2.
- R4: A command with funct code 1 loads the staging tag {vpn2, asid}, the mask and both descriptors from the slot given by the slot-number register.
- R5: A command with funct code 8 compares the staged tag against all slots. On a hit, the slot-number register becomes {0, matching slot}. When several slots match, the lowest-numbered slot wins.
- R6: When a funct-8 search finds no match, the top bit of the slot-number register is set and its low bits keep their previous value.
- R7: A slot whose global bit is 0 matches only a request with an equal address-space identifier. A slot whose global bit is 1 ignores the identifier.
- R8: Lookup compares the request's page bits [VPN_W:1] against the slot tag, ignoring the tag bits that the slot mask covers. The request bit at position popcount(mask) selects the odd half when it is 1 and the even half when it is 0. The port outputs that half's frame, valid and dirty bits, and zeros on a miss.
- R9: The replacement counter steps down by one every cycle. In the cycle after it reaches the floor value, it returns to ENTRIES-1. Writing the floor register returns the counter to ENTRIES-1 on the same edge.
- R10: A command with funct code 6 stores the staged entry into the slot named by the replacement counter's value at that edge.
- R11: A funct code other than 1, 2, 6 or 8, or any funct code while cmd_valid_i is low, changes neither the slots nor the staging registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idx_we_i | input | 1 | Write slot-number register |
| idx_wdata_i | input | IDX_W | New slot number (top flag cleared) |
| wired_we_i | input | 1 | Write floor register |
| wired_wdata_i | input | IDX_W | New floor value |
| hi_we_i | input | 1 | Write staging tag |
| hi_wdata_i | input | VPN_W+ASID_W | {vpn2, asid} |
| lo0_we_i | input | 1 | Write even descriptor |
| lo0_wdata_i | input | PFN_W+3 | {frame, dirty, valid, global} |
| lo1_we_i | input | 1 | Write odd descriptor |
| lo1_wdata_i | input | PFN_W+3 | {frame, dirty, valid, global} |
| mask_we_i | input | 1 | Write page mask |
| mask_wdata_i | input | MASK_W | Contiguous low-order ones |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_funct_i | input | 6 | Command code |
| lk_vpn_i | input | VPN_W+1 | Lookup page number at minimum granularity |
| lk_asid_i | input | ASID_W | Lookup identifier |
| index_o | output | IDX_W+1 | {miss flag, slot number} |
| random_o | output | IDX_W | Replacement counter |
| wired_o | output | IDX_W | Floor register |
| hi_o | output | VPN_W+ASID_W | Staging tag |
| lo0_o | output | PFN_W+3 | Even descriptor |
| lo1_o | output | PFN_W+3 | Odd descriptor |
| mask_o | output | MASK_W | Staging mask |
| lk_hit_o | output | 1 | Lookup matched |
| lk_pfn_o | output | PFN_W | Selected frame |
| lk_valid_o | output | 1 | Selected half valid |
| lk_dirty_o | output | 1 | Selected half dirty |

## Verification
The assertions assume that software never drives a register write port in the same cycle as a command that updates the same register. They also assume that every mask value is a run of ones starting at bit 0. The search and random-counter properties are only meaningful under these conditions. The stimulus writes registers and issues commands in separate cycles and uses only masks of the form 2^k-1. The multi-match case comes from two slots that carry the same tag, not from an overlap of masks.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [5:0] {
    CMD_READ      = 6'd1,
    CMD_WRITE_IDX = 6'd2,
    CMD_WRITE_RND = 6'd6,
    CMD_PROBE     = 6'd8
  } tlb_cmd_e;
endpackage

// File: rtl/tlb_random.sv
module tlb_random #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [IDX_W-1:0] wired_i,
  output logic [IDX_W-1:0] random_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= TOP;
    else if (reload_i)          cnt_q <= TOP;
    else if (cnt_q <= wired_i)  cnt_q <= TOP;
    else                        cnt_q <= cnt_q - 1'b1;
  end

  assign random_o = cnt_q;

  p_reload_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == TOP);
  p_step_down_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && cnt_q > wired_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int MASK_W  = 12,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]  vpn2_i [ENTRIES],
  input  logic [ASID_W-1:0] asid_i [ENTRIES],
  input  logic [MASK_W-1:0] mask_i [ENTRIES],
  input  logic              g_i    [ENTRIES],
  input  logic [VPN_W-1:0]  key_vpn2_i,
  input  logic [ASID_W-1:0] key_asid_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ENTRIES-1:0] m;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] ign;
    assign ign  = {{(VPN_W-MASK_W){1'b0}}, mask_i[i]};
    assign m[i] = (((vpn2_i[i] ^ key_vpn2_i) & ~ign) == '0) &&
                  (g_i[i] || (asid_i[i] == key_asid_i));
  end

  // lowest slot number wins
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |m;
endmodule

// File: rtl/tlb_top.sv
module tlb_top #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int MASK_W  = 12,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LO_W    = PFN_W + 3,
  parameter int HI_W    = VPN_W + ASID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [IDX_W-1:0]  idx_wdata_i,
  input  logic              wired_we_i,
  input  logic [IDX_W-1:0]  wired_wdata_i,
  input  logic              hi_we_i,
  input  logic [HI_W-1:0]   hi_wdata_i,
  input  logic              lo0_we_i,
  input  logic [LO_W-1:0]   lo0_wdata_i,
  input  logic              lo1_we_i,
  input  logic [LO_W-1:0]   lo1_wdata_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  input  logic              cmd_valid_i,
  input  logic [5:0]        cmd_funct_i,
  input  logic [VPN_W:0]    lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic [IDX_W:0]    index_o,
  output logic [IDX_W-1:0]  random_o,
  output logic [IDX_W-1:0]  wired_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [LO_W-1:0]   lo0_o,
  output logic [LO_W-1:0]   lo1_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic              lk_valid_o,
  output logic              lk_dirty_o
);
  import tlb_pkg::*;

  localparam int FD_W = PFN_W + 2; // stored half: {pfn, dirty, valid}

  logic [IDX_W:0]    index_q;
  logic [IDX_W-1:0]  wired_q, random_q;
  logic [VPN_W-1:0]  hi_vpn_q;
  logic [ASID_W-1:0] hi_asid_q;
  logic [LO_W-1:0]   lo0_q, lo1_q;
  logic [MASK_W-1:0] mask_q;

  logic [VPN_W-1:0]  e_vpn2 [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic [MASK_W-1:0] e_mask [ENTRIES];
  logic              e_g    [ENTRIES];
  logic [FD_W-1:0]   e_lo0  [ENTRIES];
  logic [FD_W-1:0]   e_lo1  [ENTRIES];

  logic is_rd, is_wi, is_wr, is_pr;
  assign is_rd = cmd_valid_i && (cmd_funct_i == CMD_READ);
  assign is_wi = cmd_valid_i && (cmd_funct_i == CMD_WRITE_IDX);
  assign is_wr = cmd_valid_i && (cmd_funct_i == CMD_WRITE_RND);
  assign is_pr = cmd_valid_i && (cmd_funct_i == CMD_PROBE);

  logic [IDX_W-1:0] wr_sel, rd_sel;
  logic             wr_ok, rd_ok;
  assign wr_sel = is_wr ? random_q : index_q[IDX_W-1:0];
  assign rd_sel = index_q[IDX_W-1:0];
  assign wr_ok  = (is_wi || is_wr) && (int'(wr_sel) < ENTRIES);
  assign rd_ok  = int'(rd_sel) < ENTRIES;

  tlb_random #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rnd (
    .clk_i, .rst_ni,
    .reload_i (wired_we_i),
    .wired_i  (wired_q),
    .random_o (random_q)
  );

  logic             pr_hit, lk_hit;
  logic [IDX_W-1:0] pr_idx, lk_idx;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
              .MASK_W(MASK_W), .IDX_W(IDX_W)) u_probe (
    .vpn2_i (e_vpn2), .asid_i (e_asid), .mask_i (e_mask), .g_i (e_g),
    .key_vpn2_i (hi_vpn_q), .key_asid_i (hi_asid_q),
    .hit_o (pr_hit), .idx_o (pr_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
              .MASK_W(MASK_W), .IDX_W(IDX_W)) u_look (
    .vpn2_i (e_vpn2), .asid_i (e_asid), .mask_i (e_mask), .g_i (e_g),
    .key_vpn2_i (lk_vpn_i[VPN_W:1]), .key_asid_i (lk_asid_i),
    .hit_o (lk_hit), .idx_o (lk_idx)
  );

  // slot array
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn2[i] <= '0;
        e_asid[i] <= '0;
        e_mask[i] <= '0;
        e_g[i]    <= 1'b0;
        e_lo0[i]  <= '0;
        e_lo1[i]  <= '0;
      end
    end else if (wr_ok) begin
      e_vpn2[wr_sel] <= hi_vpn_q;
      e_asid[wr_sel] <= hi_asid_q;
      e_mask[wr_sel] <= mask_q;
      e_g[wr_sel]    <= lo0_q[0] & lo1_q[0];
      e_lo0[wr_sel]  <= lo0_q[LO_W-1:1];
      e_lo1[wr_sel]  <= lo1_q[LO_W-1:1];
    end
  end

  // control registers; command results land after direct writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q   <= '0;
      wired_q   <= '0;
      hi_vpn_q  <= '0;
      hi_asid_q <= '0;
      lo0_q     <= '0;
      lo1_q     <= '0;
      mask_q    <= '0;
    end else begin
      if (idx_we_i)   index_q <= {1'b0, idx_wdata_i};
      if (wired_we_i) wired_q <= wired_wdata_i;
      if (hi_we_i)    {hi_vpn_q, hi_asid_q} <= hi_wdata_i;
      if (lo0_we_i)   lo0_q   <= lo0_wdata_i;
      if (lo1_we_i)   lo1_q   <= lo1_wdata_i;
      if (mask_we_i)  mask_q  <= mask_wdata_i;
      if (is_rd) begin
        if (rd_ok) begin
          hi_vpn_q  <= e_vpn2[rd_sel];
          hi_asid_q <= e_asid[rd_sel];
          mask_q    <= e_mask[rd_sel];
          lo0_q     <= {e_lo0[rd_sel], e_g[rd_sel]};
          lo1_q     <= {e_lo1[rd_sel], e_g[rd_sel]};
        end else begin
          hi_vpn_q  <= '0;
          hi_asid_q <= '0;
          mask_q    <= '0;
          lo0_q     <= '0;
          lo1_q     <= '0;
        end
      end
      if (is_pr) begin
        if (pr_hit) index_q <= {1'b0, pr_idx};
        else        index_q[IDX_W] <= 1'b1;
      end
    end
  end

  // lookup: odd/even bit sits just above the page size
  logic [FD_W-1:0] lk_half;
  int              lk_k;
  always_comb begin
    lk_k    = $countones(e_mask[lk_idx]);
    lk_half = lk_vpn_i[lk_k] ? e_lo1[lk_idx] : e_lo0[lk_idx];
    if (!lk_hit) lk_half = '0;
  end

  assign lk_hit_o   = lk_hit;
  assign lk_pfn_o   = lk_half[FD_W-1:2];
  assign lk_dirty_o = lk_half[1];
  assign lk_valid_o = lk_half[0];

  assign index_o  = index_q;
  assign random_o = random_q;
  assign wired_o  = wired_q;
  assign hi_o     = {hi_vpn_q, hi_asid_q};
  assign lo0_o    = lo0_q;
  assign lo1_o    = lo1_q;
  assign mask_o   = mask_q;

  p_probe_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pr && pr_hit && !idx_we_i) |=> index_q == {1'b0, $past(pr_idx)});
  p_probe_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pr && !pr_hit && !idx_we_i) |=>
      index_q == {1'b1, $past(index_q[IDX_W-1:0])});
  p_read_g_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && !lo0_we_i && !lo1_we_i) |=> lo0_q[0] == lo1_q[0]);
  p_random_floor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (random_q >= wired_q) || (random_q == IDX_W'(ENTRIES - 1)));
  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_pfn_o == '0 && !lk_valid_o && !lk_dirty_o));
endmodule

// File: tb/tb_tlb_top.sv
`timescale 1ns/1ps
module tb_tlb_top;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        idx_we = 0, wired_we = 0, hi_we = 0, lo0_we = 0, lo1_we = 0, mask_we = 0;
  logic [4:0]  idx_wd = 0, wired_wd = 0;
  logic [26:0] hi_wd = 0;
  logic [22:0] lo0_wd = 0, lo1_wd = 0;
  logic [11:0] mask_wd = 0;
  logic        cmd_v = 0;
  logic [5:0]  cmd_f = 0;
  logic [19:0] lk_vpn = 0;
  logic [7:0]  lk_asid = 0;
  logic [5:0]  index_o;
  logic [4:0]  random_o, wired_o;
  logic [26:0] hi_o;
  logic [22:0] lo0_o, lo1_o;
  logic [11:0] mask_o;
  logic        lk_hit, lk_valid, lk_dirty;
  logic [19:0] lk_pfn;

  tlb_top dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .idx_we_i(idx_we), .idx_wdata_i(idx_wd),
    .wired_we_i(wired_we), .wired_wdata_i(wired_wd),
    .hi_we_i(hi_we), .hi_wdata_i(hi_wd),
    .lo0_we_i(lo0_we), .lo0_wdata_i(lo0_wd),
    .lo1_we_i(lo1_we), .lo1_wdata_i(lo1_wd),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .cmd_valid_i(cmd_v), .cmd_funct_i(cmd_f),
    .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid),
    .index_o(index_o), .random_o(random_o), .wired_o(wired_o),
    .hi_o(hi_o), .lo0_o(lo0_o), .lo1_o(lo1_o), .mask_o(mask_o),
    .lk_hit_o(lk_hit), .lk_pfn_o(lk_pfn), .lk_valid_o(lk_valid), .lk_dirty_o(lk_dirty)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idx(input logic [4:0] v);
    idx_we = 1; idx_wd = v; step(); idx_we = 0;
  endtask

  task automatic set_wired(input logic [4:0] v);
    wired_we = 1; wired_wd = v; step(); wired_we = 0;
  endtask

  task automatic set_regs(input logic [18:0] vpn2, input logic [7:0] asid,
                          input logic [11:0] m, input logic [22:0] l0, input logic [22:0] l1);
    hi_we = 1; lo0_we = 1; lo1_we = 1; mask_we = 1;
    hi_wd = {vpn2, asid}; lo0_wd = l0; lo1_wd = l1; mask_wd = m;
    step();
    hi_we = 0; lo0_we = 0; lo1_we = 0; mask_we = 0;
  endtask

  task automatic set_hi(input logic [18:0] vpn2, input logic [7:0] asid);
    hi_we = 1; hi_wd = {vpn2, asid}; step(); hi_we = 0;
  endtask

  task automatic do_cmd(input logic [5:0] f);
    cmd_v = 1; cmd_f = f; step(); cmd_v = 0;
  endtask

  task automatic look(input string tag, input logic [19:0] v, input logic [7:0] a,
                      input logic hit, input logic [19:0] pfn, input logic dirty);
    lk_vpn = v; lk_asid = a; #1;
    chk({tag, " hit"}, 64'(lk_hit), 64'(hit));
    chk({tag, " pfn"}, 64'(lk_pfn), 64'(pfn));
    chk({tag, " dirty"}, 64'(lk_dirty), 64'(dirty));
  endtask

  typedef struct packed {
    logic [4:0]  idx;
    logic [18:0] vpn2;
    logic [7:0]  asid;
    logic [11:0] mask;
    logic [22:0] lo0;
    logic [22:0] lo1;
  } wr_vec_t;

  localparam wr_vec_t WR_TAB [3] = '{
    '{5'd3,  19'h00010, 8'h05, 12'h000, {20'h0AAAA, 3'b111}, {20'h0BBBB, 3'b010}},
    '{5'd7,  19'h00200, 8'h09, 12'h000, {20'h11111, 3'b111}, {20'h22222, 3'b011}},
    '{5'd12, 19'h00400, 8'h02, 12'h003, {20'h33333, 3'b010}, {20'h44444, 3'b110}}
  };

  typedef struct packed {
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic        hit;
    logic [19:0] pfn;
    logic        dirty;
  } lk_vec_t;

  // R2 stored slots visible, R7 asid rule, R8 half select and mask
  localparam lk_vec_t LK_TAB [5] = '{
    '{20'h00021, 8'h05, 1'b1, 20'h0BBBB, 1'b0},
    '{20'h00400, 8'h33, 1'b1, 20'h11111, 1'b1},
    '{20'h00806, 8'h02, 1'b1, 20'h44444, 1'b1},
    '{20'h00802, 8'h02, 1'b1, 20'h33333, 1'b0},
    '{20'h00021, 8'h06, 1'b0, 20'h00000, 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk("R1 index", 64'(index_o), 0);
    chk("R1 wired", 64'(wired_o), 0);
    chk("R1 hi", 64'(hi_o), 0);
    chk("R1 lo0", 64'(lo0_o), 0);
    chk("R1 lo1", 64'(lo1_o), 0);
    chk("R1 mask", 64'(mask_o), 0);

    // R2 write indexed from table, then walk lookups
    for (int i = 0; i < 3; i++) begin
      set_idx(WR_TAB[i].idx);
      set_regs(WR_TAB[i].vpn2, WR_TAB[i].asid, WR_TAB[i].mask, WR_TAB[i].lo0, WR_TAB[i].lo1);
      do_cmd(6'd2);
    end
    for (int i = 0; i < 5; i++) look($sformatf("R8 lookup %0d", i), LK_TAB[i].vpn,
      LK_TAB[i].asid, LK_TAB[i].hit, LK_TAB[i].pfn, LK_TAB[i].dirty);

    // R4 read indexed
    set_idx(5'd12);
    do_cmd(6'd1);
    chk("R4 hi", 64'(hi_o), 64'({19'h00400, 8'h02}));
    chk("R4 mask", 64'(mask_o), 64'h3);
    chk("R4 lo0", 64'(lo0_o), 64'({20'h33333, 3'b010}));
    chk("R4 lo1", 64'(lo1_o), 64'({20'h44444, 3'b110}));
    // R3 global AND and copy-back
    set_idx(5'd3);
    do_cmd(6'd1);
    chk("R3 lo0 g cleared", 64'(lo0_o), 64'({20'h0AAAA, 3'b110}));
    chk("R3 lo1 g", 64'(lo1_o), 64'({20'h0BBBB, 3'b010}));
    set_idx(5'd7);
    do_cmd(6'd1);
    chk("R3 lo0 g set", 64'(lo0_o[0]), 1);
    chk("R3 lo1 g set", 64'(lo1_o[0]), 1);

    // R5 probe hits
    set_hi(19'h00010, 8'h05);
    do_cmd(6'd8);
    chk("R5 probe slot3", 64'(index_o), 64'd3);
    set_hi(19'h00200, 8'h44);
    do_cmd(6'd8);
    chk("R5 R7 probe global slot7", 64'(index_o), 64'd7);
    // R6 probe miss keeps low bits
    set_hi(19'h7FFFF, 8'h77);
    do_cmd(6'd8);
    chk("R6 probe miss", 64'(index_o), 64'h27);
    set_hi(19'h00010, 8'h06);
    do_cmd(6'd8);
    chk("R6 R7 asid miss", 64'(index_o[IDX_W]), 1);

    // R5 multi-match: slot 20 duplicates slot 12 tag
    set_idx(5'd20);
    set_regs(19'h00400, 8'h02, 12'h003, {20'h66666, 3'b010}, {20'h66666, 3'b010});
    do_cmd(6'd2);
    do_cmd(6'd8);
    chk("R5 lowest slot wins", 64'(index_o), 64'd12);
    look("R5 lookup priority", 20'h00806, 8'h02, 1'b1, 20'h44444, 1'b1);

    // R9 random sequence
    set_wired(5'd28);
    chk("R9 reload", 64'(random_o), 64'd31);
    chk("R9 wired", 64'(wired_o), 64'd28);
    step(); chk("R9 step 30", 64'(random_o), 64'd30);
    step(); chk("R9 step 29", 64'(random_o), 64'd29);
    step(); chk("R9 at floor", 64'(random_o), 64'd28);
    step(); chk("R9 wrap", 64'(random_o), 64'd31);

    // R10 write random: stage, reload counter, command on next edge uses 31
    set_regs(19'h01000, 8'h01, 12'h000, {20'h55555, 3'b010}, {20'h57575, 3'b010});
    set_wired(5'd28);
    do_cmd(6'd6);
    look("R10 write random", 20'h02000, 8'h01, 1'b1, 20'h55555, 1'b0);
    set_idx(5'd31);
    do_cmd(6'd1);
    chk("R10 slot31 readback", 64'(hi_o), 64'({19'h01000, 8'h01}));

    // R11 unknown funct and strobe low
    set_idx(5'd2);
    set_regs(19'h05000, 8'h03, 12'h000, {20'h77777, 3'b010}, {20'h77777, 3'b010});
    do_cmd(6'd5);
    look("R11 funct5 no store", 20'h0A000, 8'h03, 1'b0, 20'h0, 1'b0);
    chk("R11 hi kept", 64'(hi_o), 64'({19'h05000, 8'h03}));
    chk("R11 index kept", 64'(index_o), 64'd2);
    cmd_f = 6'd2; step();
    look("R11 strobe low", 20'h0A000, 8'h03, 1'b0, 20'h0, 1'b0);
    do_cmd(6'd2);
    look("R2 store slot2", 20'h0A000, 8'h03, 1'b1, 20'h77777, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule